// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block holds a small, fully associative table of address translations and converts a 32-bit effective address into a 32-bit real address. Each table slot describes one page whose size is picked per slot, from 1 KB upward in steps of four. The lookup also checks the access rights that apply to the request. A request names the access kind (instruction fetch, data read or data write), the privilege mode, the instruction and data address-space bits, and an 8-bit process ID.

The lookup is combinational across every slot. A single register stage then presents the hit flag, the fault code, the real address, the winning slot index and the page attributes one cycle after the request strobe. A write port replaces one slot at a time. Reset loads four boot mappings so that code can run before software fills the table.

Top module: `var_page_tlb`

## Requirements
- R1: After reset all response outputs are zero. Four boot slots are loaded, each valid, with space bit 0 and TID 0. Slot 0 maps 0xF0000000 to 0xF0000000 as a 256 MB page with rights 6'b111111 and attributes 2'b11. Slot 1 maps 0x40000000 to 0x40000000 as a 256 MB page with rights 6'b001111 and attributes 2'b11. Slot 2 maps 0x80000000 to 0x80000000 as a 4 KB page with rights 6'b111111 and attributes 2'b00. Slot 3 maps 0x00000000 to 0x00000000 as a 256 MB page with rights 6'b111111 and attributes 2'b11. All other slots are invalid.
- R2: A request sampled with `req_valid` high at a rising edge produces its response after that edge, with `rsp_valid` high for exactly that cycle. When `rsp_valid` is low, `rsp_hit` and `rsp_fault` are zero.
- R3: A slot matches only when it is valid and its space bit equals the request's space bit. For a fetch (`req_kind` 2'b00) the space bit is `msr_is`. For a data read (2'b01) or a data write (2'b10 or 2'b11) it is `msr_ds`.
- R4: A slot with TID 0 matches any process ID. A slot with a nonzero TID matches only when the TID equals `req_pid`.
- R5: The compare mask is all-ones shifted left by 10 + 2×size bits. Size 0 is 1 KB, size 1 is 4 KB and size 9 is 256 MB. A shift of 32 or more (size 11 and up) gives a zero mask, so the slot covers the whole space.
- R6: On a hit with no fault, `rsp_ra` = (RPN AND mask) OR (EA AND NOT mask).
- R7: When several slots match, the lowest index wins, and its index is reported on `rsp_idx`.
- R8: On a miss, `rsp_hit`, `rsp_ra` and `rsp_idx` are zero. `rsp_fault` is 3'd1 for a data access and 3'd2 for a fetch.
- R9: The rights field is {UX,SX,UR,SR,UW,SW} on bits 5..0. A fetch that hits a slot whose execute right for the current mode is clear (UX when `req_user` is 1, SX otherwise) gives `rsp_fault` 3'd3.
- R10: A data read that hits with its read right for the mode (UR or SR) clear gives `rsp_fault` 3'd4. So does a data write that hits with its write right (UW or SW) clear. On a fault after a hit, `rsp_hit` is 1, `rsp_idx` names the slot and `rsp_ra` is zero.
- R11: A write through the port at a rising edge replaces the slot for lookups sampled from the next edge on. A lookup sampled at the same edge still sees the old contents.
- R12: On a hit, `rsp_attr` gives the slot's attribute bits {guarded, inhibited}. On a miss it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 00 fetch, 01 data read, 1x data write |
| req_user | input | 1 | 1 for user mode, 0 for supervisor |
| msr_is | input | 1 | Instruction address-space bit |
| msr_ds | input | 1 | Data address-space bit |
| req_pid | input | 8 | Process ID |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Slot to write |
| wr_epn | input | 32 | Effective page number (full address form) |
| wr_size | input | 4 | Page size code |
| wr_valid | input | 1 | Valid bit |
| wr_ts | input | 1 | Space bit |
| wr_tid | input | 8 | Owner TID, 0 for global |
| wr_rpn | input | 32 | Real page number (full address form) |
| wr_perm | input | 6 | Rights {UX,SX,UR,SR,UW,SW} |
| wr_attr | input | 2 | Attributes {guarded, inhibited} |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A slot matched |
| rsp_fault | output | 3 | 0 none, 1 data miss, 2 fetch miss, 3 fetch rights, 4 data rights |
| rsp_ra | output | 32 | Real address |
| rsp_idx | output | IDX_W | Winning slot |
| rsp_attr | output | 2 | Attributes of winning slot |

## Verification
Several properties are checked on every cycle. A response appears only in the cycle after a strobe, and it is quiet otherwise. A miss always carries a miss code with a zeroed address. A fetch never reports a data-side fault, and a data access never reports a fetch-side fault. Every clean hit keeps the low ten address bits unchanged. Some behaviour can only be shown by the bench's scenarios, because the expected result depends on table contents that the assertions do not model. This covers the boot mappings, the per-size masking, TID and space matching, lowest-index priority, the rights checks in each mode, and the exact edge at which a written slot takes effect.

// File: rtl/var_page_tlb.sv
module var_page_tlb #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_ea,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic             msr_is,
  input  logic             msr_ds,
  input  logic [7:0]       req_pid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_epn,
  input  logic [3:0]       wr_size,
  input  logic             wr_valid,
  input  logic             wr_ts,
  input  logic [7:0]       wr_tid,
  input  logic [31:0]      wr_rpn,
  input  logic [5:0]       wr_perm,
  input  logic [1:0]       wr_attr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [2:0]       rsp_fault,
  output logic [31:0]      rsp_ra,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [1:0]       rsp_attr
);

  localparam logic [2:0] F_NONE = 3'd0;
  localparam logic [2:0] F_DMISS = 3'd1;
  localparam logic [2:0] F_IMISS = 3'd2;
  localparam logic [2:0] F_IRGT = 3'd3;
  localparam logic [2:0] F_DRGT = 3'd4;

  logic [31:0] t_epn  [ENTRIES];
  logic [31:0] t_rpn  [ENTRIES];
  logic [3:0]  t_size [ENTRIES];
  logic        t_v    [ENTRIES];
  logic        t_ts   [ENTRIES];
  logic [7:0]  t_tid  [ENTRIES];
  logic [5:0]  t_perm [ENTRIES];
  logic [1:0]  t_attr [ENTRIES];

  function automatic logic [31:0] page_mask(input logic [3:0] sz);
    logic [5:0] sh;
    sh = 6'd10 + {1'b0, sz, 1'b0};
    return (sh >= 6'd32) ? 32'h0 : (32'hFFFF_FFFF << sh);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        t_v[i]    <= 1'b0;
        t_ts[i]   <= 1'b0;
        t_tid[i]  <= 8'h0;
        t_epn[i]  <= 32'h0;
        t_rpn[i]  <= 32'h0;
        t_size[i] <= 4'd0;
        t_perm[i] <= 6'h0;
        t_attr[i] <= 2'b00;
      end
      t_v[0] <= 1'b1; t_epn[0] <= 32'hF000_0000; t_rpn[0] <= 32'hF000_0000;
      t_size[0] <= 4'd9; t_perm[0] <= 6'b111111; t_attr[0] <= 2'b11;
      t_v[1] <= 1'b1; t_epn[1] <= 32'h4000_0000; t_rpn[1] <= 32'h4000_0000;
      t_size[1] <= 4'd9; t_perm[1] <= 6'b001111; t_attr[1] <= 2'b11;
      t_v[2] <= 1'b1; t_epn[2] <= 32'h8000_0000; t_rpn[2] <= 32'h8000_0000;
      t_size[2] <= 4'd1; t_perm[2] <= 6'b111111; t_attr[2] <= 2'b00;
      t_v[3] <= 1'b1; t_epn[3] <= 32'h0000_0000; t_rpn[3] <= 32'h0000_0000;
      t_size[3] <= 4'd9; t_perm[3] <= 6'b111111; t_attr[3] <= 2'b11;
    end else if (wr_en) begin
      t_v[wr_idx]    <= wr_valid;
      t_ts[wr_idx]   <= wr_ts;
      t_tid[wr_idx]  <= wr_tid;
      t_epn[wr_idx]  <= wr_epn;
      t_rpn[wr_idx]  <= wr_rpn;
      t_size[wr_idx] <= wr_size;
      t_perm[wr_idx] <= wr_perm;
      t_attr[wr_idx] <= wr_attr;
    end
  end

  wire is_fetch = (req_kind == 2'b00);
  wire is_write = req_kind[1];
  wire space    = is_fetch ? msr_is : msr_ds;

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    wire [31:0] m = page_mask(t_size[g]);
    assign match[g] = t_v[g] && (t_ts[g] == space) &&
                      ((t_tid[g] == 8'h0) || (t_tid[g] == req_pid)) &&
                      ((t_epn[g] & m) == (req_ea & m));
  end

  logic             any;
  logic [IDX_W-1:0] sel;
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  wire [5:0]  p     = t_perm[sel];
  wire [31:0] smask = page_mask(t_size[sel]);
  wire right = is_fetch ? (req_user ? p[5] : p[4]) :
               is_write ? (req_user ? p[1] : p[0]) :
                          (req_user ? p[3] : p[2]);
  wire [2:0] fault = !any ? (is_fetch ? F_IMISS : F_DMISS) :
                     right ? F_NONE : (is_fetch ? F_IRGT : F_DRGT);
  wire [31:0] ra = (t_rpn[sel] & smask) | (req_ea & ~smask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= F_NONE;
      rsp_ra    <= 32'h0;
      rsp_idx   <= '0;
      rsp_attr  <= 2'b00;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any;
      rsp_fault <= req_valid ? fault : F_NONE;
      rsp_ra    <= (req_valid && fault == F_NONE) ? ra : 32'h0;
      rsp_idx   <= (req_valid && any) ? sel : '0;
      rsp_attr  <= (req_valid && any) ? t_attr[sel] : 2'b00;
    end
  end

endmodule

module var_page_tlb_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [31:0]      req_ea,
  input logic [1:0]       req_kind,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [2:0]       rsp_fault,
  input logic [31:0]      rsp_ra,
  input logic [IDX_W-1:0] rsp_idx
);

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && rsp_fault == 3'd0));
  a_r8_miss_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> ((rsp_fault == 3'd1 || rsp_fault == 3'd2)
                                 && rsp_ra == 32'h0 && rsp_idx == '0));
  a_r9_fetch_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b00) |=> (rsp_fault != 3'd1 && rsp_fault != 3'd4));
  a_r10_data_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'b00) |=> (rsp_fault != 3'd2 && rsp_fault != 3'd3));
  a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_fault != 3'd0 || rsp_ra[9:0] == $past(req_ea[9:0])));

endmodule

bind var_page_tlb var_page_tlb_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
  .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .rsp_ra(rsp_ra), .rsp_idx(rsp_idx)
);

// File: tb/tb_var_page_tlb.sv
module tb_var_page_tlb;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0] req_kind = '0;
  logic req_user = 1'b0, msr_is = 1'b0, msr_ds = 1'b0;
  logic [7:0] req_pid = '0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_epn = '0, wr_rpn = '0;
  logic [3:0] wr_size = '0;
  logic wr_valid = 1'b0, wr_ts = 1'b0;
  logic [7:0] wr_tid = '0;
  logic [5:0] wr_perm = '0;
  logic [1:0] wr_attr = '0;
  logic rsp_valid, rsp_hit;
  logic [2:0] rsp_fault;
  logic [31:0] rsp_ra;
  logic [IW-1:0] rsp_idx;
  logic [1:0] rsp_attr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  var_page_tlb #(.ENTRIES(16)) dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] epn, input logic [3:0] sz,
                     input logic v, input logic ts, input logic [7:0] tid,
                     input logic [31:0] rpn, input logic [5:0] perm, input logic [1:0] attr);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_epn = epn; wr_size = sz; wr_valid = v;
    wr_ts = ts; wr_tid = tid; wr_rpn = rpn; wr_perm = perm; wr_attr = attr;
  endtask

  task automatic write_slot(input int idx, input logic [31:0] epn, input logic [3:0] sz,
                            input logic v, input logic ts, input logic [7:0] tid,
                            input logic [31:0] rpn, input logic [5:0] perm, input logic [1:0] attr);
    @(negedge clk);
    put(idx, epn, sz, v, ts, tid, rpn, perm, attr);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string tag, input logic [31:0] ea, input logic [1:0] kind,
                      input logic user, input logic is_b, input logic ds_b, input logic [7:0] pid,
                      input logic hit, input logic [2:0] flt, input logic [31:0] ra, input int idx);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_kind = kind; req_user = user;
    msr_is = is_b; msr_ds = ds_b; req_pid = pid;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " hit"}, 32'(rsp_hit), 32'(hit));
    check({tag, " fault"}, 32'(rsp_fault), 32'(flt));
    check({tag, " ra"}, rsp_ra, ra);
    check({tag, " idx"}, 32'(rsp_idx), 32'(idx));
  endtask

  task automatic t_reset();
    check("R1 reset valid", 32'(rsp_valid), 0);
    check("R1 reset hit", 32'(rsp_hit), 0);
    check("R1 reset fault", 32'(rsp_fault), 0);
    check("R1 reset ra", rsp_ra, 0);
    look("R1 boot0 fetch", 32'hF000_1234, 2'b00, 1'b0, 1'b0, 1'b0, 8'h0, 1, 3'd0, 32'hF000_1234, 0);
    check("R12 boot0 attr", 32'(rsp_attr), 32'd3);
    look("R1 boot2 read", 32'h8000_0ABC, 2'b01, 1'b1, 1'b0, 1'b0, 8'h0, 1, 3'd0, 32'h8000_0ABC, 2);
    check("R12 boot2 attr", 32'(rsp_attr), 32'd0);
    look("R1 boot1 user write", 32'h4000_0020, 2'b10, 1'b1, 1'b0, 1'b0, 8'h0, 1, 3'd0, 32'h4000_0020, 1);
    look("R9 boot1 no exec", 32'h4000_0010, 2'b00, 1'b0, 1'b0, 1'b0, 8'h0, 1, 3'd3, 32'h0, 1);
    @(negedge clk);
    check("R2 idle after response", 32'(rsp_valid), 0);
  endtask

  task automatic t_miss_and_space();
    look("R8 data miss", 32'h5000_0000, 2'b01, 1'b0, 1'b0, 1'b0, 8'h0, 0, 3'd1, 32'h0, 0);
    check("R12 miss attr", 32'(rsp_attr), 0);
    look("R8 fetch miss", 32'h5000_0000, 2'b00, 1'b0, 1'b0, 1'b0, 8'h0, 0, 3'd2, 32'h0, 0);
    look("R3 ds=1 data miss", 32'hF000_0000, 2'b01, 1'b0, 1'b0, 1'b1, 8'h0, 0, 3'd1, 32'h0, 0);
    look("R3 is=1 fetch miss", 32'hF000_0040, 2'b00, 1'b0, 1'b1, 1'b0, 8'h0, 0, 3'd2, 32'h0, 0);
    look("R3 is=1 data uses ds", 32'hF000_0040, 2'b01, 1'b0, 1'b1, 1'b0, 8'h0, 1, 3'd0, 32'hF000_0040, 0);
  endtask

  task automatic t_tid_and_rights();
    write_slot(5, 32'h1234_5000, 4'd1, 1'b1, 1'b0, 8'd7, 32'hABCD_E000, 6'b001000, 2'b01);
    look("R4 R6 tid match", 32'h1234_5678, 2'b01, 1'b1, 1'b0, 1'b0, 8'd7, 1, 3'd0, 32'hABCD_E678, 5);
    check("R12 slot5 attr", 32'(rsp_attr), 32'd1);
    look("R4 tid mismatch", 32'h1234_5678, 2'b01, 1'b1, 1'b0, 1'b0, 8'd8, 0, 3'd1, 32'h0, 0);
    look("R4 pid0 vs tid7", 32'h1234_5678, 2'b01, 1'b1, 1'b0, 1'b0, 8'd0, 0, 3'd1, 32'h0, 0);
    look("R4 global any pid", 32'hF000_0100, 2'b01, 1'b1, 1'b0, 1'b0, 8'h55, 1, 3'd0, 32'hF000_0100, 0);
    look("R10 sup read no SR", 32'h1234_5678, 2'b01, 1'b0, 1'b0, 1'b0, 8'd7, 1, 3'd4, 32'h0, 5);
    look("R10 user write no UW", 32'h1234_5678, 2'b10, 1'b1, 1'b0, 1'b0, 8'd7, 1, 3'd4, 32'h0, 5);
    look("R10 kind 11 is write", 32'h1234_5678, 2'b11, 1'b1, 1'b0, 1'b0, 8'd7, 1, 3'd4, 32'h0, 5);
    look("R9 user fetch no UX", 32'h1234_5678, 2'b00, 1'b1, 1'b0, 1'b0, 8'd7, 1, 3'd3, 32'h0, 5);
    write_slot(5, 32'h1234_5000, 4'd1, 1'b1, 1'b0, 8'd7, 32'hABCD_E000, 6'b010000, 2'b01);
    look("R9 sup fetch SX", 32'h1234_5678, 2'b00, 1'b0, 1'b0, 1'b0, 8'd7, 1, 3'd0, 32'hABCD_E678, 5);
    look("R9 user fetch only SX", 32'h1234_5678, 2'b00, 1'b1, 1'b0, 1'b0, 8'd7, 1, 3'd3, 32'h0, 5);
  endtask

  task automatic t_sizes();
    write_slot(6, 32'h2000_0400, 4'd0, 1'b1, 1'b0, 8'd0, 32'h3000_0800, 6'h3F, 2'b00);
    look("R5 1KB inside", 32'h2000_07FF, 2'b01, 1'b0, 1'b0, 1'b0, 8'h0, 1, 3'd0, 32'h3000_0BFF, 6);
    look("R5 1KB next page", 32'h2000_0800, 2'b01, 1'b0, 1'b0, 1'b0, 8'h0, 0, 3'd1, 32'h0, 0);
    write_slot(7, 32'h0, 4'd11, 1'b1, 1'b1, 8'd0, 32'hFFFF_FFFF, 6'h3F, 2'b10);
    look("R5 whole space", 32'h1357_2468, 2'b01, 1'b0, 1'b0, 1'b1, 8'h0, 1, 3'd0, 32'h1357_2468, 7);
  endtask

  task automatic t_priority();
    write_slot(8, 32'hF000_0000, 4'd1, 1'b1, 1'b0, 8'd0, 32'h1111_1000, 6'h3F, 2'b00);
    look("R7 lower wins", 32'hF000_0ABC, 2'b01, 1'b0, 1'b0, 1'b0, 8'h0, 1, 3'd0, 32'hF000_0ABC, 0);
    write_slot(0, 32'hF000_0000, 4'd9, 1'b0, 1'b0, 8'd0, 32'hF000_0000, 6'h3F, 2'b11);
    look("R7 next after invalidate", 32'hF000_0ABC, 2'b01, 1'b0, 1'b0, 1'b0, 8'h0, 1, 3'd0, 32'h1111_1ABC, 8);
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    put(9, 32'h6000_0000, 4'd5, 1'b1, 1'b0, 8'd0, 32'h0A50_0000, 6'h3F, 2'b00);
    req_valid = 1'b1; req_ea = 32'h6001_2345; req_kind = 2'b01; req_user = 1'b0;
    msr_is = 1'b0; msr_ds = 1'b0; req_pid = 8'h0;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check("R11 same edge old hit", 32'(rsp_hit), 0);
    check("R11 same edge old fault", 32'(rsp_fault), 1);
    look("R11 next edge new", 32'h6001_2345, 2'b01, 1'b0, 1'b0, 1'b0, 8'h0, 1, 3'd0, 32'h0A51_2345, 9);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_and_space();
    t_tid_and_rights();
    t_sizes();
    t_priority();
    t_write_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule